// File: doc/BRIEF.md
# Caller ID Bit-Stream Framer

This block sits behind the FSK demodulator of a telephone-line caller ID receiver. It takes the recovered bit stream, one level (`bit_val`, 1 = mark, 0 = space) qualified by a one-cycle strobe (`bit_stb`) per bit. It searches for the line preamble and raises a carrier flag once it finds one. It then cuts the following stream into asynchronous characters and hands each good character to the host with a one-cycle valid pulse. Message parsing, checksums and detecting the end of a message are left to the host, which ends reception by clearing `enable`.

Two detectors are available. In strict mode (`tol_mode` = 0), a run of alternating bits must come first, followed by a run of consecutive marks. In tolerant mode (`tol_mode` = 1), the alternating run is optional. With `dot_en` also set, a single space inside the mark run is forgiven. In that case, the first character after carrier is checked against a table of six message-type codes before it is accepted.

Top module: `cid_rx_framer`

## Requirements
- R1: After reset, `carrier` and `data_vld` are 0 and `data` is 0x00.
- R2: In strict mode the carrier search tracks two run lengths, one of alternating bits and one of consecutive marks. A space that follows a space, or that follows two or more marks, breaks a completed alternating run. `carrier` rises at the clock edge that samples a mark strobe when two conditions hold: an alternating run of at least `seize_min` bits has completed and not been broken, and the consecutive-mark count (which includes the mark that ended the alternating run) has reached `mark_min`. A `mark_min` of 0 acts as 1. A mark run with no prior alternating run never raises `carrier`.
- R3: In tolerant mode, `mark_min` consecutive marks raise `carrier` without any alternating run.
- R4: In tolerant mode with `dot_en` = 1, one space inside a mark run leaves the mark count unchanged. A second space in the same run clears the count. With `dot_en` = 0, any space clears the count.
- R5: While `carrier` is 1, a character is one space start bit, then 8 data bits LSB first, then a mark stop bit. At the edge that samples the stop strobe, `data` takes the character and `data_vld` pulses for one cycle.
- R6: A character whose stop bit is a space produces no `data_vld`, and `data` keeps its previous value. The framer then hunts for a new start bit.
- R7: In tolerant mode with `dot_en` = 1, the first character after carrier must equal one of the six entries of `msg_codes` (entry k at bits 8k+7:8k). If it does not, `carrier` falls, no `data_vld` is issued, and the search restarts from zero counts.
- R8: When `enable` is 0 or `sender_en` is 1, the next edge clears `carrier`, `data_vld`, the search counts and the framer state. These stay cleared while that condition holds. `data` is kept.
- R9: Once `carrier` is up, characters keep being delivered, one after another, until the block is disabled. Only the first character is checked against the code table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Decoder enable from host |
| sender_en | input | 1 | Caller ID sender active; blocks the decoder |
| tol_mode | input | 1 | 0 = strict detector, 1 = tolerant detector |
| dot_en | input | 1 | Drop-out tolerance and code check (tolerant mode only) |
| seize_min | input | 5 | Minimum alternating run length |
| mark_min | input | 5 | Required consecutive marks |
| msg_codes | input | 48 | Six valid first-character codes, entry k at bits 8k+7:8k |
| bit_stb | input | 1 | One-cycle strobe for a demodulated bit |
| bit_val | input | 1 | Bit level, 1 = mark, 0 = space |
| carrier | output | 1 | Carrier detected |
| data_vld | output | 1 | One-cycle pulse: new character in `data` |
| data | output | 8 | Last received character |

## Verification
The bench drives a mark run with no alternating preamble in strict mode. A design that ignored the seizure requirement would raise carrier there. It drops a single space into the mark run both with and without drop-out tolerance. A design that reset its count, or failed to reset it, would detect carrier too late or too early. It sends a character with a space stop bit, which a careless framer would still deliver. It sends a first character that is not in the code table, which must drop carrier instead of producing a valid pulse. Finally, it raises the sender enable in the middle of detection, which must hold the block idle.

// File: rtl/cid_pkg.sv
package cid_pkg;

    localparam int unsigned RUN_W  = 5;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = $clog2(BYTE_W);

    typedef logic [RUN_W-1:0]  run_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DATA = 2'd1,
        FR_STOP = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic  done;
        logic  stop_ok;
        byte_t value;
    } fr_out_t;

    function automatic run_t run_inc(run_t v);
        return (&v) ? v : run_t'(v + 1'b1);
    endfunction

    function automatic run_t run_floor(run_t v);
        return (v == '0) ? run_t'(1) : v;
    endfunction

endpackage

// File: rtl/cid_carrier_det.sv
module cid_carrier_det
    import cid_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic stb,
    input  logic bit_val,
    input  logic tol_mode,
    input  logic dot_en,
    input  run_t seize_min,
    input  run_t mark_min,
    output logic hit
);

    logic have_prev, prev_bit, drop_used, seize_ok;
    run_t alt_run, mark_run;

    logic alt_nx_cont, drop_nx, seize_nx, brk;
    run_t alt_nx, mark_nx;

    always_comb begin
        alt_nx_cont = !have_prev || (bit_val != prev_bit);
        alt_nx      = alt_nx_cont ? run_inc(alt_run) : run_t'(1);

        if (bit_val) begin
            mark_nx = run_inc(mark_run);
            drop_nx = drop_used;
        end else if (tol_mode && dot_en && mark_run != '0 && !drop_used) begin
            mark_nx = mark_run;
            drop_nx = 1'b1;
        end else begin
            mark_nx = '0;
            drop_nx = 1'b0;
        end

        brk      = !bit_val && have_prev && (!prev_bit || mark_run >= run_t'(2));
        seize_nx = (seize_ok && !brk) || (alt_nx >= seize_min);

        hit = stb && bit_val && (mark_nx >= run_floor(mark_min))
              && (tol_mode || seize_nx);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
            drop_used <= 1'b0;
            seize_ok  <= 1'b0;
            alt_run   <= '0;
            mark_run  <= '0;
        end else if (stb) begin
            have_prev <= 1'b1;
            prev_bit  <= bit_val;
            drop_used <= drop_nx;
            seize_ok  <= seize_nx && !tol_mode;
            alt_run   <= alt_nx;
            mark_run  <= mark_nx;
        end
    end

endmodule

// File: rtl/cid_byte_framer.sv
module cid_byte_framer
    import cid_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    stb,
    input  logic    bit_val,
    output fr_out_t fo
);

    fr_state_e        state;
    logic [IDX_W-1:0] idx;
    byte_t            shreg;

    always_comb begin
        fo.done    = stb && (state == FR_STOP);
        fo.stop_ok = bit_val;
        fo.value   = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state <= FR_IDLE;
            idx   <= '0;
            shreg <= '0;
        end else if (stb) begin
            unique case (state)
                FR_IDLE: begin
                    if (!bit_val) begin
                        state <= FR_DATA;
                        idx   <= '0;
                    end
                end
                FR_DATA: begin
                    shreg <= {bit_val, shreg[BYTE_W-1:1]};
                    idx   <= idx + 1'b1;
                    if (idx == IDX_W'(BYTE_W - 1))
                        state <= FR_STOP;
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cid_rx_framer.sv
module cid_rx_framer
    import cid_pkg::*;
#(
    parameter int unsigned N_CODES = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic                      sender_en,
    input  logic                      tol_mode,
    input  logic                      dot_en,
    input  logic [RUN_W-1:0]          seize_min,
    input  logic [RUN_W-1:0]          mark_min,
    input  logic [N_CODES*BYTE_W-1:0] msg_codes,
    input  logic                      bit_stb,
    input  logic                      bit_val,
    output logic                      carrier,
    output logic                      data_vld,
    output logic [BYTE_W-1:0]         data
);

    logic    en_eff, det_hit, need_code, code_ok;
    fr_out_t fo;
    logic [N_CODES-1:0] code_vec;

    assign en_eff = enable && !sender_en;

    cid_carrier_det u_det (
        .clk       (clk),
        .rst       (rst),
        .clr       (!en_eff || carrier),
        .stb       (bit_stb),
        .bit_val   (bit_val),
        .tol_mode  (tol_mode),
        .dot_en    (dot_en),
        .seize_min (seize_min),
        .mark_min  (mark_min),
        .hit       (det_hit)
    );

    cid_byte_framer u_frm (
        .clk     (clk),
        .rst     (rst),
        .run     (carrier && en_eff),
        .stb     (bit_stb),
        .bit_val (bit_val),
        .fo      (fo)
    );

    for (genvar k = 0; k < N_CODES; k++) begin : g_code
        assign code_vec[k] = (msg_codes[k*BYTE_W +: BYTE_W] == fo.value);
    end
    assign code_ok = |code_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            carrier   <= 1'b0;
            need_code <= 1'b0;
            data_vld  <= 1'b0;
            data      <= '0;
        end else if (!en_eff) begin
            carrier   <= 1'b0;
            need_code <= 1'b0;
            data_vld  <= 1'b0;
        end else begin
            data_vld <= 1'b0;
            if (!carrier) begin
                if (det_hit) begin
                    carrier   <= 1'b1;
                    need_code <= tol_mode && dot_en;
                end
            end else if (fo.done && fo.stop_ok) begin
                if (need_code && !code_ok) begin
                    carrier   <= 1'b0;
                    need_code <= 1'b0;
                end else begin
                    need_code <= 1'b0;
                    data      <= fo.value;
                    data_vld  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cid_rx_framer_chk.sv
module cid_rx_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       sender_en,
    input logic       tol_mode,
    input logic       dot_en,
    input logic       bit_stb,
    input logic       bit_val,
    input logic       carrier,
    input logic       data_vld,
    input logic [7:0] data
);

    // R5
    vld_needs_carrier_chk: assert property (@(posedge clk) disable iff (rst)
        data_vld |-> $past(carrier));

    // R5
    vld_on_stop_mark_chk: assert property (@(posedge clk) disable iff (rst)
        data_vld |-> ($past(bit_stb) && $past(bit_val)));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !data_vld |-> $stable(data));

    // R8
    off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !(enable && !sender_en) |=> (!carrier && !data_vld));

    // R2
    carrier_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(carrier) |-> ($past(bit_stb) && $past(bit_val)));

    // R7
    carrier_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(carrier) |-> ($past(!enable || sender_en)
                            || $past(bit_stb && bit_val && tol_mode && dot_en)));

endmodule

bind cid_rx_framer cid_rx_framer_chk chk_i (.*);

// File: tb/cid_rx_framer_tb_top.sv
`timescale 1ns/1ps
module cid_rx_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0, sender_en = 1'b0, tol_mode = 1'b0, dot_en = 1'b0;
    logic [4:0]  seize_min = 5'd8, mark_min = 5'd10;
    logic [47:0] msg_codes = {8'h82, 8'h82, 8'h82, 8'h80, 8'h06, 8'h04};
    logic        bit_stb = 1'b0, bit_val = 1'b1;
    logic        carrier, data_vld;
    logic [7:0]  data;

    int checks = 0, errors = 0, cyc = 0;
    int vld_seen = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    cid_rx_framer dut_i (
        .clk(clk), .rst(rst), .enable(enable), .sender_en(sender_en),
        .tol_mode(tol_mode), .dot_en(dot_en), .seize_min(seize_min),
        .mark_min(mark_min), .msg_codes(msg_codes), .bit_stb(bit_stb),
        .bit_val(bit_val), .carrier(carrier), .data_vld(data_vld), .data(data)
    );

    // Behavioural reference model
    int m_car, m_vld, m_data, m_need;
    int s_have, s_prev, s_alt, s_mark, s_drop, s_seize;
    int f_st, f_cnt, f_val;

    function automatic int sat(int v);
        return (v > 31) ? 31 : v;
    endfunction

    task automatic m_clear_search();
        s_have = 0; s_prev = 0; s_alt = 0; s_mark = 0; s_drop = 0; s_seize = 0;
    endtask

    always @(posedge clk) begin
        int b, brk, mm, hit, ok;
        cyc++;
        if (rst) begin
            m_car = 0; m_vld = 0; m_data = 0; m_need = 0;
            m_clear_search(); f_st = 0; f_cnt = 0; f_val = 0;
        end else if (!(enable && !sender_en)) begin
            m_car = 0; m_vld = 0; m_need = 0;
            m_clear_search(); f_st = 0; f_cnt = 0; f_val = 0;
        end else begin
            m_vld = 0;
            b = int'(bit_val);
            if (bit_stb && !m_car) begin
                brk = (!b && s_have && (!s_prev || s_mark >= 2));
                s_alt = (!s_have || b != s_prev) ? sat(s_alt + 1) : 1;
                if (b) s_mark = sat(s_mark + 1);
                else if (tol_mode && dot_en && s_mark != 0 && !s_drop) s_drop = 1;
                else begin s_mark = 0; s_drop = 0; end
                s_seize = ((s_seize && !brk) || s_alt >= int'(seize_min)) ? 1 : 0;
                mm = (mark_min == 0) ? 1 : int'(mark_min);
                hit = b && s_mark >= mm && (tol_mode || s_seize);
                s_have = 1; s_prev = b;
                if (tol_mode) s_seize = 0;
                if (hit) begin
                    m_car = 1; m_need = tol_mode && dot_en;
                    m_clear_search(); f_st = 0;
                end
            end else if (bit_stb && m_car) begin
                if (f_st == 0) begin
                    if (!b) begin f_st = 1; f_cnt = 0; f_val = 0; end
                end else if (f_st == 1) begin
                    f_val = f_val | (b << f_cnt);
                    f_cnt++;
                    if (f_cnt == 8) f_st = 2;
                end else begin
                    f_st = 0;
                    if (b) begin
                        ok = 0;
                        for (int k = 0; k < 6; k++)
                            if (int'(msg_codes[k*8 +: 8]) == f_val) ok = 1;
                        if (m_need && !ok) begin
                            m_car = 0; m_need = 0;
                        end else begin
                            m_need = 0; m_data = f_val; m_vld = 1;
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            checks++;
            if (int'(carrier) != m_car) begin
                errors++;
                $display("FAIL R2 R3 R4 R7 R8 carrier: actual %0d expected %0d @%0d", carrier, m_car, cyc);
            end
            checks++;
            if (int'(data_vld) != m_vld) begin
                errors++;
                $display("FAIL R5 R6 data_vld: actual %0d expected %0d @%0d", data_vld, m_vld, cyc);
            end
            checks++;
            if (int'(data) != m_data) begin
                errors++;
                $display("FAIL R5 R9 data: actual %02h expected %02h @%0d", data, m_data[7:0], cyc);
            end
            if (data_vld) vld_seen++;
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    task automatic expect_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge clk); bit_stb = 1'b1; bit_val = b;
        @(negedge clk); bit_stb = 1'b0; bit_val = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_marks(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_seize(int n);
        for (int i = 0; i < n; i++) send_bit(logic'(i % 2));
    endtask

    task automatic send_char(logic [7:0] v, logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        send_bit(stop);
    endtask

    task automatic restart();
        @(negedge clk); enable = 1'b0;
        repeat (2) @(negedge clk);
        expect_eq("R8 carrier after disable", int'(carrier), 0);
        enable = 1'b1;
    endtask

    initial begin
        int v0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_eq("R1 carrier", int'(carrier), 0);
        expect_eq("R1 data_vld", int'(data_vld), 0);
        expect_eq("R1 data", int'(data), 0);

        // Strict mode with seizure
        enable = 1'b1;
        send_seize(10);
        send_marks(12);
        expect_eq("R2 carrier after seizure+marks", int'(carrier), 1);
        v0 = vld_seen;
        send_char(8'hA5, 1'b1);
        expect_eq("R5 data A5", int'(data), 8'hA5);
        send_char(8'h3C, 1'b1);
        expect_eq("R9 second char", int'(data), 8'h3C);
        send_char(8'hF0, 1'b0);
        expect_eq("R6 bad stop keeps data", int'(data), 8'h3C);
        expect_eq("R6 no pulse for bad stop", vld_seen - v0, 2);
        send_marks(2);
        send_char(8'h5A, 1'b1);
        expect_eq("R6 framer recovers", int'(data), 8'h5A);
        restart();

        // Strict mode, marks only
        send_marks(20);
        expect_eq("R2 no carrier without seizure", int'(carrier), 0);
        restart();

        // Tolerant, no drop-out tolerance
        tol_mode = 1'b1;
        send_marks(5); send_bit(1'b0); send_marks(6);
        expect_eq("R4 space resets count without dot", int'(carrier), 0);
        send_marks(4);
        expect_eq("R3 carrier without seizure", int'(carrier), 1);
        send_char(8'h11, 1'b1);
        expect_eq("R3 char delivered, no code check", int'(data), 8'h11);
        restart();

        // Tolerant with drop-out tolerance
        dot_en = 1'b1;
        send_marks(5); send_bit(1'b0); send_marks(5);
        expect_eq("R4 drop-out tolerated", int'(carrier), 1);
        send_char(8'h80, 1'b1);
        expect_eq("R7 listed code accepted", int'(data), 8'h80);
        send_char(8'h55, 1'b1);
        expect_eq("R9 later char not code-checked", int'(data), 8'h55);
        restart();

        send_marks(4); send_bit(1'b0); send_bit(1'b0); send_marks(9);
        expect_eq("R4 double space resets", int'(carrier), 0);
        send_marks(1);
        expect_eq("R4 carrier after fresh run", int'(carrier), 1);
        v0 = vld_seen;
        send_char(8'h12, 1'b1);
        expect_eq("R7 carrier dropped on bad code", int'(carrier), 0);
        expect_eq("R7 no pulse on bad code", vld_seen - v0, 0);
        expect_eq("R7 data kept", int'(data), 8'h55);
        send_marks(10);
        expect_eq("R7 search restarted", int'(carrier), 1);

        // Sender active blocks decoder
        @(negedge clk); sender_en = 1'b1;
        @(negedge clk);
        expect_eq("R8 sender clears carrier", int'(carrier), 0);
        send_marks(15);
        expect_eq("R8 held idle while sender on", int'(carrier), 0);
        sender_en = 1'b0;
        mark_min = 5'd0;
        send_marks(1);
        expect_eq("R2 mark_min zero acts as one", int'(carrier), 1);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule